// File: doc/BRIEF.md
# Memory Stack Call/Return Unit

This block keeps a last-in-first-out stack in data memory. A 16-bit stack pointer register addresses it. The block handles plain push and pop of data words. It also sequences the memory traffic for a subroutine call and for an interrupt entry, both of which save the program counter and the status register. It handles the two kinds of return as well. A subroutine return restores only a masked group of status bits. An interrupt return restores the whole status word.

The controller raises one command strobe per operation. The block drives a synchronous single-port memory, where read data appears on the cycle after the read is issued. Restored values come back on output buses together with one-cycle valid strobes.

The control is a finite state machine with these states:
- `ST_IDLE` accepts a command.
- `ST_PUSH_WR` performs the write phase of a push.
- `ST_CALL_PC` writes the program counter.
- `ST_CALL_SR` writes the status word.
- `ST_RET_SR` delivers the saved status word and reads the program counter.
- `ST_RET_PC` delivers the program counter.

The transitions are:
- From `ST_IDLE`: a push goes to `ST_PUSH_WR`. A call or interrupt entry goes to `ST_CALL_PC`. Either return goes to `ST_RET_SR`. A pop, or no command, stays in `ST_IDLE`.
- `ST_PUSH_WR` goes to `ST_IDLE`.
- `ST_CALL_PC` goes to `ST_CALL_SR`, which then goes to `ST_IDLE`.
- `ST_RET_SR` goes to `ST_RET_PC`, which then goes to `ST_IDLE`.

Top module: `stk_unit`

## Requirements
- R1: On reset the pointer `sp` equals the parameter `BASE`. On reset `busy`, `pop_valid`, `sr_valid` and `pc_valid` are all low.
- R2: An accepted push raises `sp` by one at the accepting edge. On the next cycle the block writes `push_data` at the new `sp` and holds `busy` high for that one cycle.
- R3: An accepted pop reads the word at the current `sp` and lowers `sp` by one at the accepting edge. In the following cycle `pop_valid` is high and `pop_data` carries that word. `busy` stays low.
- R4: An accepted call or interrupt entry writes `pc_in` at `sp+1` and then writes `sr_in` at `sp+2`, on the two cycles after acceptance. It leaves `sp` two higher, and `busy` is high for those two cycles.
- R5: An accepted return reads the status word at `sp` and then the program counter at `sp-1`, leaving `sp` two lower. `sr_valid` is high in the first cycle after acceptance and `pc_valid` is high in the second. `pc_out` is the word read from `sp-1`.
- R6: On a subroutine return, `sr_out` takes the bits selected by `PX_MASK` (default 16'h001F, the low five bits) from the stack. It takes every other bit from `sr_in` as driven in the `sr_valid` cycle.
- R7: On an interrupt return, `sr_out` equals the whole stacked status word.
- R8: While `busy` is high, every command input is ignored.
- R9: When several commands are raised together in idle, exactly one is accepted. The order of precedence, highest first, is interrupt entry, call, interrupt return, subroutine return, push, pop.
- R10: The stack pointer wraps modulo 2^16 in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_push | input | 1 | Push `push_data` |
| push_data | input | DW | Word to push |
| cmd_pop | input | 1 | Pop one word |
| cmd_call | input | 1 | Subroutine call |
| cmd_int | input | 1 | Interrupt entry |
| cmd_rts | input | 1 | Subroutine return |
| cmd_rti | input | 1 | Interrupt return |
| pc_in | input | DW | Program counter to save |
| sr_in | input | DW | Current status word |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | SP_W | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, one cycle after the read |
| busy | output | 1 | Multi-cycle sequence in progress |
| pop_valid | output | 1 | `pop_data` valid |
| pop_data | output | DW | Popped word |
| sr_valid | output | 1 | `sr_out` valid |
| sr_out | output | DW | Restored status word |
| pc_valid | output | 1 | `pc_out` valid |
| pc_out | output | DW | Restored program counter |
| sp | output | SP_W | Stack pointer |

## Verification
The assertions rely on three assumptions about the environment:
- The memory returns the addressed word exactly one cycle after a read.
- `sr_in` stays stable while a return sequence runs.
- The command strobes are driven only between clock edges.

The bench's memory model answers with fixed one-cycle latency. It holds `sr_in` constant through each return and changes commands only at falling edges. Overlapping and blocked commands are raised on purpose, because precedence and the ignoring of commands while busy are part of the defined behaviour.

// File: rtl/stk_pkg.sv
package stk_pkg;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_INT,
        CMD_CALL,
        CMD_RTI,
        CMD_RTS,
        CMD_PUSH,
        CMD_POP
    } stk_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH_WR,
        ST_CALL_PC,
        ST_CALL_SR,
        ST_RET_SR,
        ST_RET_PC
    } stk_state_e;

endpackage

// File: rtl/stk_cmd_arb.sv
module stk_cmd_arb
    import stk_pkg::*;
(
    input  logic     en,
    input  logic     cmd_int,
    input  logic     cmd_call,
    input  logic     cmd_rti,
    input  logic     cmd_rts,
    input  logic     cmd_push,
    input  logic     cmd_pop,
    output stk_cmd_e cmd
);
    // Fixed precedence, highest first.
    always_comb begin
        cmd = CMD_NONE;
        if (en) begin
            if (cmd_int)       cmd = CMD_INT;
            else if (cmd_call) cmd = CMD_CALL;
            else if (cmd_rti)  cmd = CMD_RTI;
            else if (cmd_rts)  cmd = CMD_RTS;
            else if (cmd_push) cmd = CMD_PUSH;
            else if (cmd_pop)  cmd = CMD_POP;
        end
    end
endmodule

// File: rtl/stk_ptr.sv
module stk_ptr #(
    parameter int              SP_W = 16,
    parameter logic [SP_W-1:0] BASE = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            inc,
    input  logic            dec,
    output logic [SP_W-1:0] sp
);
    localparam logic [SP_W-1:0] ONE = {{(SP_W-1){1'b0}}, 1'b1};

    // Natural modulo-2^SP_W arithmetic gives the wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)   sp <= BASE;
        else if (inc) sp <= sp + ONE;
        else if (dec) sp <= sp - ONE;
    end
endmodule

// File: rtl/stk_sr_merge.sv
module stk_sr_merge #(
    parameter int            DW   = 16,
    parameter logic [DW-1:0] MASK = 'h1F
) (
    input  logic          full,
    input  logic [DW-1:0] cur,
    input  logic [DW-1:0] saved,
    output logic [DW-1:0] merged
);
    always_comb begin
        if (full) merged = saved;
        else      merged = (cur & ~MASK) | (saved & MASK);
    end
endmodule

// File: rtl/stk_unit.sv
module stk_unit
    import stk_pkg::*;
#(
    parameter int              DW      = 16,
    parameter int              SP_W    = 16,
    parameter logic [SP_W-1:0] BASE    = 'h0100,
    parameter logic [DW-1:0]   PX_MASK = 'h001F
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_push,
    input  logic [DW-1:0]   push_data,
    input  logic            cmd_pop,
    input  logic            cmd_call,
    input  logic            cmd_int,
    input  logic            cmd_rts,
    input  logic            cmd_rti,
    input  logic [DW-1:0]   pc_in,
    input  logic [DW-1:0]   sr_in,
    output logic            mem_en,
    output logic            mem_we,
    output logic [SP_W-1:0] mem_addr,
    output logic [DW-1:0]   mem_wdata,
    input  logic [DW-1:0]   mem_rdata,
    output logic            busy,
    output logic            pop_valid,
    output logic [DW-1:0]   pop_data,
    output logic            sr_valid,
    output logic [DW-1:0]   sr_out,
    output logic            pc_valid,
    output logic [DW-1:0]   pc_out,
    output logic [SP_W-1:0] sp
);
    stk_state_e      state_q, state_d;
    stk_cmd_e        cmd;
    logic            sp_inc, sp_dec;
    logic [DW-1:0]   hold_a_q;
    logic [DW-1:0]   hold_b_q;
    logic            is_rti_q;
    logic            pop_pend_q;

    stk_cmd_arb u_arb (
        .en       (state_q == ST_IDLE),
        .cmd_int  (cmd_int),
        .cmd_call (cmd_call),
        .cmd_rti  (cmd_rti),
        .cmd_rts  (cmd_rts),
        .cmd_push (cmd_push),
        .cmd_pop  (cmd_pop),
        .cmd      (cmd)
    );

    stk_ptr #(.SP_W(SP_W), .BASE(BASE)) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (sp_inc),
        .dec   (sp_dec),
        .sp    (sp)
    );

    stk_sr_merge #(.DW(DW), .MASK(PX_MASK)) u_merge (
        .full   (is_rti_q),
        .cur    (sr_in),
        .saved  (mem_rdata),
        .merged (sr_out)
    );

    // State and capture registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            hold_a_q   <= '0;
            hold_b_q   <= '0;
            is_rti_q   <= 1'b0;
            pop_pend_q <= 1'b0;
        end else begin
            state_q    <= state_d;
            pop_pend_q <= (cmd == CMD_POP);
            if (cmd != CMD_NONE) begin
                hold_a_q <= (cmd == CMD_PUSH) ? push_data : pc_in;
                hold_b_q <= sr_in;
                is_rti_q <= (cmd == CMD_RTI);
            end
        end
    end

    // Next-state decode.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                case (cmd)
                    CMD_PUSH:         state_d = ST_PUSH_WR;
                    CMD_CALL, CMD_INT: state_d = ST_CALL_PC;
                    CMD_RTS, CMD_RTI: state_d = ST_RET_SR;
                    default:          state_d = ST_IDLE;
                endcase
            end
            ST_PUSH_WR: state_d = ST_IDLE;
            ST_CALL_PC: state_d = ST_CALL_SR;
            ST_CALL_SR: state_d = ST_IDLE;
            ST_RET_SR:  state_d = ST_RET_PC;
            ST_RET_PC:  state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Outputs: memory port and pointer steps.
    always_comb begin
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = sp;
        mem_wdata = hold_a_q;
        sp_inc    = 1'b0;
        sp_dec    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                case (cmd)
                    CMD_PUSH, CMD_CALL, CMD_INT: sp_inc = 1'b1;
                    CMD_POP, CMD_RTS, CMD_RTI: begin
                        mem_en = 1'b1;
                        sp_dec = 1'b1;
                    end
                    default: ;
                endcase
            end
            ST_PUSH_WR: begin
                mem_en = 1'b1;
                mem_we = 1'b1;
            end
            ST_CALL_PC: begin
                mem_en = 1'b1;
                mem_we = 1'b1;
                sp_inc = 1'b1;
            end
            ST_CALL_SR: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = hold_b_q;
            end
            ST_RET_SR: begin
                mem_en = 1'b1;
                sp_dec = 1'b1;
            end
            ST_RET_PC: ;
            default: ;
        endcase
    end

    assign busy      = (state_q != ST_IDLE);
    assign pop_valid = pop_pend_q;
    assign pop_data  = mem_rdata;
    assign sr_valid  = (state_q == ST_RET_SR);
    assign pc_valid  = (state_q == ST_RET_PC);
    assign pc_out    = mem_rdata;

    AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> !busy && !pop_valid && sp == BASE); // R1
    AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == CMD_PUSH |=> mem_we && busy && sp == $past(sp) + 1'b1 && mem_addr == sp); // R2
    AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == CMD_POP |=> pop_valid && !busy && sp == $past(sp) - 1'b1); // R3
    AST_CALL_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_CALL_SR |-> mem_we && $past(mem_we) && mem_addr == $past(mem_addr) + 1'b1); // R4
    AST_PC_AFTER_SR: assert property (@(posedge clk) disable iff (!rst_n)
        pc_valid |-> $past(sr_valid)); // R5
    AST_RTS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        sr_valid && !is_rti_q |-> (sr_out & ~PX_MASK) == (sr_in & ~PX_MASK)); // R6
    AST_RTI_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        sr_valid && is_rti_q |-> sr_out == mem_rdata); // R7
    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> cmd == CMD_NONE); // R8
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({pop_valid, sr_valid, pc_valid}) <= 1); // R5
endmodule

// File: tb/tb_stk_unit.sv
`timescale 1ns/1ps
module tb_stk_unit;
    localparam int          DW   = 16;
    localparam int          SW   = 16;
    localparam logic [15:0] BASE = 16'hFFF8;
    localparam logic [15:0] MSK  = 16'h001F;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_push = 0, cmd_pop = 0, cmd_call = 0, cmd_int = 0, cmd_rts = 0, cmd_rti = 0;
    logic [DW-1:0] push_data = '0, pc_in = '0, sr_in = '0;
    logic mem_en, mem_we, busy, pop_valid, sr_valid, pc_valid;
    logic [SW-1:0] mem_addr, sp;
    logic [DW-1:0] mem_wdata, mem_rdata, pop_data, sr_out, pc_out;

    int tests = 0;
    int fails = 0;
    bit done = 0;
    logic [15:0] ref_sp;
    logic [15:0] ref_stk [256];
    logic [15:0] mem [256];

    always #10 clk = ~clk;

    stk_unit #(.DW(DW), .SP_W(SW), .BASE(BASE), .PX_MASK(MSK)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_push(cmd_push), .push_data(push_data),
        .cmd_pop(cmd_pop), .cmd_call(cmd_call), .cmd_int(cmd_int),
        .cmd_rts(cmd_rts), .cmd_rti(cmd_rti), .pc_in(pc_in), .sr_in(sr_in),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy(busy),
        .pop_valid(pop_valid), .pop_data(pop_data), .sr_valid(sr_valid),
        .sr_out(sr_out), .pc_valid(pc_valid), .pc_out(pc_out), .sp(sp)
    );

    // One-cycle read latency memory over the low address byte.
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
            mem_rdata <= mem[mem_addr[7:0]];
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] rts_sr(input logic [15:0] cur, input logic [15:0] st);
        return (cur & ~MSK) | (st & MSK);
    endfunction

    task automatic do_push(input logic [15:0] d, input bit also_pop, input bit inject);
        cmd_push = 1; cmd_pop = also_pop; push_data = d;
        @(negedge clk);
        cmd_push = 0; cmd_pop = 0;
        ref_sp = ref_sp + 16'd1;
        chk("R2 busy", busy, 1);
        chk("R2 sp", sp, ref_sp);
        cmd_call = inject; cmd_pop = inject;
        @(negedge clk);
        cmd_call = 0; cmd_pop = 0;
        ref_stk[ref_sp[7:0]] = d;
        chk("R2 idle", busy, 0);
        chk("R8 sp", sp, ref_sp);
    endtask

    task automatic do_pop();
        cmd_pop = 1;
        @(negedge clk);
        cmd_pop = 0;
        chk("R3 valid", pop_valid, 1);
        chk("R3 data", pop_data, ref_stk[ref_sp[7:0]]);
        chk("R3 busy", busy, 0);
        ref_sp = ref_sp - 16'd1;
        chk("R3 sp", sp, ref_sp);
    endtask

    task automatic do_call(input logic [15:0] pc, input logic [15:0] sr, input bit is_int, input bit also_push);
        cmd_call = !is_int; cmd_int = is_int; cmd_push = also_push;
        pc_in = pc; sr_in = sr; push_data = 16'hDEAD;
        @(negedge clk);
        cmd_call = 0; cmd_int = 0; cmd_push = 0;
        chk("R4 busy1", busy, 1);
        @(negedge clk);
        chk("R4 busy2", busy, 1);
        @(negedge clk);
        ref_stk[8'(ref_sp[7:0] + 8'd1)] = pc;
        ref_stk[8'(ref_sp[7:0] + 8'd2)] = sr;
        ref_sp = ref_sp + 16'd2;
        chk("R4 idle", busy, 0);
        chk("R4 R9 sp", sp, ref_sp);
    endtask

    task automatic do_ret(input bit rti, input bit both, input logic [15:0] cur);
        logic [15:0] exp_sr;
        cmd_rti = rti | both; cmd_rts = !rti | both; sr_in = cur;
        @(negedge clk);
        cmd_rti = 0; cmd_rts = 0;
        exp_sr = (rti | both) ? ref_stk[ref_sp[7:0]] : rts_sr(cur, ref_stk[ref_sp[7:0]]);
        chk("R5 sr_valid", sr_valid, 1);
        chk(rti | both ? "R7 R9 sr" : "R6 sr", sr_out, exp_sr);
        @(negedge clk);
        chk("R5 pc_valid", pc_valid, 1);
        chk("R5 pc", pc_out, ref_stk[8'(ref_sp[7:0] - 8'd1)]);
        @(negedge clk);
        ref_sp = ref_sp - 16'd2;
        chk("R5 idle", busy, 0);
        chk("R5 sp", sp, ref_sp);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED));
        for (int i = 0; i < 256; i++) begin
            mem[i] = '0;
            ref_stk[i] = '0;
        end
        ref_sp = BASE;
        repeat (3) @(negedge clk);
        chk("R1 sp", sp, BASE);
        chk("R1 busy", busy, 0);
        chk("R1 valids", {pop_valid, sr_valid, pc_valid}, 0);
        rst_n = 1;
        @(negedge clk);
        // Directed: wrap upward and back down (R10).
        for (int i = 0; i < 10; i++) do_push(16'h1000 + 16'(i), 0, 0);
        chk("R10 wrap up", sp, 16'h0002);
        for (int i = 0; i < 10; i++) do_pop();
        chk("R10 wrap down", sp, BASE);
        do_push(16'hA5A5, 1, 0);   // R9 push over pop
        do_push(16'h5A5A, 0, 1);   // R8 commands during busy
        do_call(16'h1234, 16'hFFE3, 0, 1); // R9 call over push
        do_ret(0, 0, 16'h0F00);    // R6
        do_call(16'h4321, 16'h00FF, 1, 0);
        do_ret(1, 1, 16'hAAAA);    // R7, R9 rti over rts
        for (int n = 0; n < 400; n++) begin
            int op;
            op = int'($urandom_range(0, 5));
            case (op)
                0: do_push(16'($urandom), 0, 0);
                1: do_pop();
                2: do_call(16'($urandom), 16'($urandom), 0, 0);
                3: do_call(16'($urandom), 16'($urandom), 1, 0);
                4: do_ret(0, 0, 16'($urandom));
                default: do_ret(1, 0, 16'($urandom));
            endcase
        end
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule